// File: doc/BRIEF.md
# Two-Wire DAC Setpoint Write Slave

This block is a receive-only slave on a two-wire serial bus (I2C-style signalling). It takes setpoint writes for a digital-to-analog converter from a bus master. A fast system clock samples the clock line and the data line, and the block finds frame boundaries from those samples. It answers one 7-bit device address. The upper four bits of that address are fixed, and three strap pins set the lower three bits.

Each accepted byte goes into a shadow register. The three shadow registers hold the command byte, the low data byte and the high data byte. Nothing visible changes while the frame is in progress. When the closing condition arrives and the frame is complete, the shadow contents move into the output registers in one step, and a one-cycle strobe marks the change. A converter that follows the outputs therefore never sees a half-written code.

The block accepts three frame shapes: address only, address plus command, and address plus command plus two data bytes. It never drives read data and never holds the clock low.

Top module: `dac_wr_slave`

## Requirements
- R1: While reset is active and right after it, `dac_code_o` and `cmd_o` are 0, `upd_stb_o` is 0 and `sda_oe_o` is 0 (the bus is released).
- R2: A frame opens only on a start condition: SDA falls while SCL is high, as seen on the synchronized lines. It closes on a stop condition: SDA rises while SCL is high. Bytes clocked without a preceding start get no acknowledge.
- R3: The address byte is sent MSB first. Its upper seven bits must equal {4'b0100, strap_i[2:0]} (with `ALT_PREFIX`=1 the fixed part is 4'b0011), and bit 0 (the direction bit) must be 0. When both hold, the slave acknowledges.
- R4: After an address that does not match, or one whose direction bit is 1, the slave sends no acknowledge. It then acknowledges no further byte, and the following stop changes no output.
- R5: In a full write frame (address, command, low data byte, high data byte), each byte is acknowledged. At the stop, `cmd_o` takes the command byte and `dac_code_o` takes {high[1:0], low[7:0]}. The upper six bits of the high byte are ignored.
- R6: The acknowledge holds SDA low through the whole high phase of the ninth clock. `sda_oe_o` changes only while the synchronized SCL is low.
- R7: Before the stop, neither `dac_code_o` nor `cmd_o` changes, even after all bytes have been acknowledged.
- R8: An address-plus-command frame loads `cmd_o` at the stop, leaves `dac_code_o` unchanged and pulses the strobe once.
- R9: An address-only frame is acknowledged, changes no output and gives no strobe.
- R10: A frame that stops after the low data byte, or in the middle of a byte, changes no output and gives no strobe.
- R11: A repeated start restarts address decoding and discards the unfinished frame. A complete frame that follows it takes effect at its stop.
- R12: A fifth byte after a full write gets no acknowledge, and the stop that follows discards the whole frame.
- R13: `upd_stb_o` is high for exactly one cycle, the cycle after stop detection, and only when an output register loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Low three bits of the device address |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| dac_code_o | output | DAC_W | Converter code from the last complete write |
| cmd_o | output | 8 | Command byte from the last loaded frame |
| upd_stb_o | output | 1 | One-cycle pulse when the output registers load |

## Verification
The bench builds the block with its default parameters: the 0100 prefix, two synchronizer stages and a 10-bit code. It models the open-drain bus as a wired AND of the master and the slave. With the 3-bit strap, every pairing of strap value and addressed device fits in a 64-frame sweep, so every match and every mismatch is observed. Each sweep frame also carries high-byte junk in the ignored bits. Separate frames cover every frame length the block accepts, the truncated and over-long frames, the read direction, the wrong prefix and the repeated start.

// File: rtl/dws_pkg.sv
package dws_pkg;

  localparam logic [3:0] PFX_MAIN = 4'b0100;
  localparam logic [3:0] PFX_ALT  = 4'b0011;
  localparam logic [3:0] BYTE_BITS = 4'd8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_ACK  = 2'd2,
    ST_SKIP = 2'd3
  } dws_state_e;

  // index of a payload byte inside a frame, in arrival order
  localparam logic [1:0] SEL_CMD = 2'd0;
  localparam logic [1:0] SEL_LSB = 2'd1;
  localparam logic [1:0] SEL_MSB = 2'd2;
  localparam logic [1:0] SEL_FULL = 2'd3;

endpackage

// File: rtl/dws_line_sync.sv
module dws_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_p;
  logic              sda_p;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[i] <= 1'b1;
          sda_q[i] <= 1'b1;
        end else begin
          scl_q[i] <= scl_i;
          sda_q[i] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[i] <= 1'b1;
          sda_q[i] <= 1'b1;
        end else begin
          scl_q[i] <= scl_q[i-1];
          sda_q[i] <= sda_q[i-1];
        end
      end
    end
  end

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/dws_frame_fsm.sv
module dws_frame_fsm
  import dws_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [6:0] dev_addr,
  output logic       sda_oe,
  output logic       byte_we,
  output logic [1:0] byte_sel,
  output logic [7:0] byte_data,
  output logic       commit_cmd,
  output logic       commit_dac
);

  dws_state_e state_q, state_d;
  logic [3:0] bit_cnt_q, bit_cnt_d;
  logic [7:0] shreg_q, shreg_d;
  logic [1:0] nbytes_q, nbytes_d;
  logic       addr_ph_q, addr_ph_d;
  logic       ack_hi_q, ack_hi_d;
  logic       oe_q, oe_d;
  logic       at_boundary;

  // the stop condition's own SCL rise has shifted one bit in
  assign at_boundary = (state_q == ST_RX) && !addr_ph_q && (bit_cnt_q == 4'd1);

  always_comb begin
    state_d    = state_q;
    bit_cnt_d  = bit_cnt_q;
    shreg_d    = shreg_q;
    nbytes_d   = nbytes_q;
    addr_ph_d  = addr_ph_q;
    ack_hi_d   = ack_hi_q;
    oe_d       = oe_q;
    byte_we    = 1'b0;
    commit_cmd = 1'b0;
    commit_dac = 1'b0;
    if (start_det) begin
      state_d   = ST_RX;
      bit_cnt_d = 4'd0;
      nbytes_d  = SEL_CMD;
      addr_ph_d = 1'b1;
      ack_hi_d  = 1'b0;
      oe_d      = 1'b0;
    end else if (stop_det) begin
      if (at_boundary) begin
        commit_cmd = (nbytes_q == SEL_LSB) || (nbytes_q == SEL_FULL);
        commit_dac = (nbytes_q == SEL_FULL);
      end
      state_d  = ST_IDLE;
      oe_d     = 1'b0;
      ack_hi_d = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_d   = {shreg_q[6:0], sda_s};
            bit_cnt_d = bit_cnt_q + 4'd1;
          end else if (scl_fall && (bit_cnt_q == BYTE_BITS)) begin
            if (addr_ph_q) begin
              if ((shreg_q[7:1] == dev_addr) && !shreg_q[0]) begin
                addr_ph_d = 1'b0;
                oe_d      = 1'b1;
                state_d   = ST_ACK;
              end else begin
                state_d = ST_SKIP;
              end
            end else if (nbytes_q == SEL_FULL) begin
              state_d = ST_SKIP;
            end else begin
              byte_we  = 1'b1;
              nbytes_d = nbytes_q + 2'd1;
              oe_d     = 1'b1;
              state_d  = ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_rise) begin
            ack_hi_d = 1'b1;
          end else if (scl_fall && ack_hi_q) begin
            ack_hi_d  = 1'b0;
            oe_d      = 1'b0;
            bit_cnt_d = 4'd0;
            state_d   = ST_RX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= 4'd0;
      shreg_q   <= 8'd0;
      nbytes_q  <= SEL_CMD;
      addr_ph_q <= 1'b1;
      ack_hi_q  <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      bit_cnt_q <= bit_cnt_d;
      shreg_q   <= shreg_d;
      nbytes_q  <= nbytes_d;
      addr_ph_q <= addr_ph_d;
      ack_hi_q  <= ack_hi_d;
      oe_q      <= oe_d;
    end
  end

  assign sda_oe    = oe_q;
  assign byte_sel  = nbytes_q;
  assign byte_data = shreg_q;

endmodule

// File: rtl/dws_regs.sv
module dws_regs
  import dws_pkg::*;
#(
  parameter int DAC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_we,
  input  logic [1:0]       byte_sel,
  input  logic [7:0]       byte_data,
  input  logic             commit_cmd,
  input  logic             commit_dac,
  output logic [DAC_W-1:0] dac_code,
  output logic [7:0]       cmd,
  output logic             upd_stb
);

  localparam int MSB_W = DAC_W - 8;

  logic [7:0]       cmd_sh_q, cmd_sh_d;
  logic [7:0]       lsb_sh_q, lsb_sh_d;
  logic [MSB_W-1:0] msb_sh_q, msb_sh_d;
  logic [7:0]       cmd_q, cmd_d;
  logic [DAC_W-1:0] dac_q, dac_d;
  logic             stb_q, stb_d;

  always_comb begin
    cmd_sh_d = cmd_sh_q;
    lsb_sh_d = lsb_sh_q;
    msb_sh_d = msb_sh_q;
    if (byte_we) begin
      case (byte_sel)
        SEL_CMD: cmd_sh_d = byte_data;
        SEL_LSB: lsb_sh_d = byte_data;
        SEL_MSB: msb_sh_d = byte_data[MSB_W-1:0];
        default: ;
      endcase
    end
    cmd_d = commit_cmd ? cmd_sh_q : cmd_q;
    dac_d = commit_dac ? {msb_sh_q, lsb_sh_q} : dac_q;
    stb_d = commit_cmd | commit_dac;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_sh_q <= 8'd0;
      lsb_sh_q <= 8'd0;
      msb_sh_q <= '0;
      cmd_q    <= 8'd0;
      dac_q    <= '0;
      stb_q    <= 1'b0;
    end else begin
      cmd_sh_q <= cmd_sh_d;
      lsb_sh_q <= lsb_sh_d;
      msb_sh_q <= msb_sh_d;
      cmd_q    <= cmd_d;
      dac_q    <= dac_d;
      stb_q    <= stb_d;
    end
  end

  assign dac_code = dac_q;
  assign cmd      = cmd_q;
  assign upd_stb  = stb_q;

endmodule

// File: rtl/dac_wr_slave.sv
module dac_wr_slave
  import dws_pkg::*;
#(
  parameter bit ALT_PREFIX  = 1'b0,
  parameter int SYNC_STAGES = 2,
  parameter int DAC_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [2:0]       strap_i,
  output logic             sda_oe_o,
  output logic [DAC_W-1:0] dac_code_o,
  output logic [7:0]       cmd_o,
  output logic             upd_stb_o
);

  localparam logic [3:0] FIXED_PFX = ALT_PREFIX ? PFX_ALT : PFX_MAIN;

  logic       rst_meta;
  logic       rst_sync;
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;
  logic [6:0] dev_addr;
  logic       byte_we;
  logic [1:0] byte_sel;
  logic [7:0] byte_data;
  logic       commit_cmd;
  logic       commit_dac;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign dev_addr = {FIXED_PFX, strap_i};

  dws_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  dws_frame_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_addr  (dev_addr),
    .sda_oe    (sda_oe_o),
    .byte_we   (byte_we),
    .byte_sel  (byte_sel),
    .byte_data (byte_data),
    .commit_cmd(commit_cmd),
    .commit_dac(commit_dac)
  );

  dws_regs #(
    .DAC_W(DAC_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync),
    .byte_we   (byte_we),
    .byte_sel  (byte_sel),
    .byte_data (byte_data),
    .commit_cmd(commit_cmd),
    .commit_dac(commit_dac),
    .dac_code  (dac_code_o),
    .cmd       (cmd_o),
    .upd_stb   (upd_stb_o)
  );

endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
  parameter int DAC_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             stop_det,
  input logic             sda_oe,
  input logic             upd_stb,
  input logic [DAC_W-1:0] dac_code,
  input logic [7:0]       cmd
);

  // R13: strobe follows a detected stop by one cycle
  a_r13_stb_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> $past(stop_det));

  // R13: strobe is a single-cycle pulse
  a_r13_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  // R7: outputs move only together with the strobe
  a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> ($stable(dac_code) && $stable(cmd)));

  // R6: acknowledge drive starts only while SCL is low
  a_r6_oe_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R6: acknowledge drive ends only while SCL is low
  a_r6_oe_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s);

endmodule

bind dac_wr_slave dws_checker #(.DAC_W(DAC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_s   (scl_s),
  .stop_det(stop_det),
  .sda_oe  (sda_oe_o),
  .upd_stb (upd_stb_o),
  .dac_code(dac_code_o),
  .cmd     (cmd_o)
);

// File: tb/dac_wr_slave_tb.sv
module dac_wr_slave_tb;

  localparam int Q = 8;

  logic       clk;
  logic       rst_n;
  logic       scl_m;
  logic       sda_m;
  logic [2:0] strap;
  logic       sda_oe;
  logic [9:0] dac_code;
  logic [7:0] cmd;
  logic       upd_stb;
  logic       sda_line;

  int n_chk  = 0;
  int n_fail = 0;
  int stb_cnt = 0;
  logic [9:0] exp_dac;
  logic [7:0] exp_cmd;
  bit done = 0;

  assign sda_line = sda_m & ~sda_oe;

  dac_wr_slave u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .strap_i   (strap),
    .sda_oe_o  (sda_oe),
    .dac_code_o(dac_code),
    .cmd_o     (cmd),
    .upd_stb_o (upd_stb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) if (upd_stb) stb_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(3);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(1);
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; wq(1);
    end
  endtask

  // R6: acknowledge must read low early and late in the high phase
  task automatic xfer(input logic [7:0] b, output logic ack);
    logic s1, s2;
    send_bits(b, 8);
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    s1 = sda_line;
    repeat (2 * Q - 2) @(negedge clk);
    s2 = sda_line;
    @(negedge clk); @(negedge clk);
    scl_m = 1'b0; wq(1);
    ack = !s1 && !s2;
  endtask

  task automatic outs(input string req);
    chk(req, 32'(dac_code), 32'(exp_dac));
    chk(req, 32'(cmd), 32'(exp_cmd));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic ack;
    int s0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 3'd0;
    exp_dac = '0; exp_cmd = '0;
    repeat (5) @(negedge clk);
    // R1: reset values
    chk("R1 dac", 32'(dac_code), 0);
    chk("R1 cmd", 32'(cmd), 0);
    chk("R1 oe", 32'(sda_oe), 0);
    chk("R1 stb", 32'(upd_stb), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 after release", {dac_code, cmd, sda_oe, upd_stb}, 0);

    // R2: bytes without a start are not acknowledged
    scl_m = 1'b0; wq(1);
    xfer({4'b0100, 3'd0, 1'b0}, ack);
    chk("R2 no start no ack", 32'(ack), 0);
    bus_stop();
    outs("R2 outputs");

    // R3 R4 R5 R7 R13: strap x address sweep
    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < 8; a++) begin
        logic [7:0] c, l, m;
        logic match;
        c = {3'(s), 3'(a), 2'b10};
        l = 8'(s * 32 + a * 5 + 3);
        m = {3'(a), 3'(s), 2'(a + s)};
        match = (s == a);
        strap = 3'(s);
        s0 = stb_cnt;
        bus_start();
        xfer({4'b0100, 3'(a), 1'b0}, ack);
        chk("R3 addr ack", 32'(ack), 32'(match));
        xfer(c, ack);
        chk("R5 R4 cmd ack", 32'(ack), 32'(match));
        xfer(l, ack);
        chk("R5 R4 lsb ack", 32'(ack), 32'(match));
        xfer(m, ack);
        chk("R5 R4 msb ack", 32'(ack), 32'(match));
        outs("R7 before stop");
        bus_stop();
        if (match) begin
          exp_cmd = c;
          exp_dac = {m[1:0], l};
        end
        outs("R5 R4 after stop");
        chk("R13 strobe count", 32'(stb_cnt - s0), 32'(match));
      end
    end

    strap = 3'd5;
    // R4: read direction
    s0 = stb_cnt;
    bus_start();
    xfer({4'b0100, 3'd5, 1'b1}, ack);
    chk("R4 read bit no ack", 32'(ack), 0);
    xfer(8'h77, ack);
    chk("R4 later byte no ack", 32'(ack), 0);
    bus_stop();
    outs("R4 read outputs");
    chk("R4 no strobe", 32'(stb_cnt - s0), 0);

    // R3: wrong fixed prefix
    bus_start();
    xfer({4'b0011, 3'd5, 1'b0}, ack);
    chk("R3 wrong prefix", 32'(ack), 0);
    bus_stop();

    // R8: address plus command
    s0 = stb_cnt;
    bus_start();
    xfer({4'b0100, 3'd5, 1'b0}, ack);
    chk("R8 addr ack", 32'(ack), 1);
    xfer(8'hA5, ack);
    chk("R8 cmd ack", 32'(ack), 1);
    bus_stop();
    exp_cmd = 8'hA5;
    outs("R8 cmd only");
    chk("R8 strobe", 32'(stb_cnt - s0), 1);

    // R9: address only
    s0 = stb_cnt;
    bus_start();
    xfer({4'b0100, 3'd5, 1'b0}, ack);
    chk("R9 addr ack", 32'(ack), 1);
    bus_stop();
    outs("R9 no change");
    chk("R9 no strobe", 32'(stb_cnt - s0), 0);

    // R10: stop after low data byte
    s0 = stb_cnt;
    bus_start();
    xfer({4'b0100, 3'd5, 1'b0}, ack);
    xfer(8'h3C, ack);
    xfer(8'h99, ack);
    bus_stop();
    outs("R10 short frame");
    chk("R10 no strobe short", 32'(stb_cnt - s0), 0);
    // R10: stop inside the high byte
    bus_start();
    xfer({4'b0100, 3'd5, 1'b0}, ack);
    xfer(8'h3D, ack);
    xfer(8'h98, ack);
    send_bits(8'hFF, 4);
    bus_stop();
    outs("R10 mid byte");
    chk("R10 no strobe mid", 32'(stb_cnt - s0), 0);

    // R11: repeated start
    s0 = stb_cnt;
    bus_start();
    xfer({4'b0100, 3'd5, 1'b0}, ack);
    xfer(8'h11, ack);
    xfer(8'h22, ack);
    bus_rstart();
    xfer({4'b0100, 3'd5, 1'b0}, ack);
    chk("R11 addr ack after restart", 32'(ack), 1);
    xfer(8'h33, ack);
    xfer(8'h44, ack);
    xfer(8'hFD, ack);
    chk("R11 msb ack", 32'(ack), 1);
    bus_stop();
    exp_cmd = 8'h33;
    exp_dac = 10'h144;
    outs("R11 second frame");
    chk("R11 strobe", 32'(stb_cnt - s0), 1);

    // R12: one byte too many
    s0 = stb_cnt;
    bus_start();
    xfer({4'b0100, 3'd5, 1'b0}, ack);
    xfer(8'h55, ack);
    xfer(8'h66, ack);
    xfer(8'h02, ack);
    xfer(8'h88, ack);
    chk("R12 extra nack", 32'(ack), 0);
    bus_stop();
    outs("R12 discarded");
    chk("R12 no strobe", 32'(stb_cnt - s0), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule